// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block computes the control-register and program-counter updates a soft processor makes when it enters an exception handler. The core presents a one-cycle request with a cause code, the current program counter, the current status word, the current cause and TLB-miscellaneous registers, and two vector addresses: a general vector and a fast TLB-miss vector. On the next clock edge the block presents the new value of each affected register together with a write strobe for it. The core's register file commits every strobed value in that same cycle.

The cause class and the exception-handling flag that was already in status together decide three things: whether the saved status and return address are overwritten, which saved-status and return register pair is used, and which vector is taken. A TLB miss taken while a handler is already active becomes a nested miss to the general vector. It leaves the saved state alone and marks the double-miss bit. Unknown cause codes raise an error flag and strobe nothing.

All pins are plain control and data pins. There is no back-pressure: a request is accepted in every cycle it is high, and the result always appears on the following cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, done, error and every write strobe are low.
- R2: A request sampled at a clock edge raises done for exactly the following cycle. Write strobes and the error flag are high only in a cycle where done is high.
- R3: Status bits are laid out as follows: bit 0 is previous-interrupt-enable, bit 1 is user mode, bit 2 is exception-handling and bit 3 is interrupt-handling. On every accepted entry the new status is the old status with bits 0 and 1 cleared and with bit 2 set. An interrupt sets bit 3 instead of bit 2. All other bits keep their old value.
- R4: On every accepted entry the new cause register holds the 5-bit cause code in bits 6:2, and every other bit keeps its old value.
- R5: Code 0 is an interrupt. It is accepted only if status bit 0 is set. When accepted, it writes exception-status = old status and exception-return = PC+4, and jumps to the general vector. When status bit 0 is clear, done pulses and no strobe is raised.
- R6: Code 1 with status bit 2 clear is a fast TLB miss. It writes exception-status = old status and exception-return = PC+4. In the TLB-misc register it clears bit 1 (double miss) and sets bit 0 (write enable). It then jumps to the fast TLB-miss vector.
- R7: Code 1 with status bit 2 set is a double miss. It sets TLB-misc bit 1, leaves exception-status and exception-return unwritten, and jumps to the general vector.
- R8: Codes 2, 3 and 4 are read, write and execute permission faults. Each writes exception-status and exception-return = PC+4 and jumps to the general vector. TLB-misc bit 0 is set and written only when status bit 2 was clear before the entry.
- R9: Codes 5, 6 and 7 are supervisor-only faults, and codes 8 and 9 are trap and illegal instruction. These write exception-status and exception-return only when status bit 2 was clear before the entry, and always jump to the general vector.
- R10: Code 10 is a break. It writes break-status = old status and break-return = PC+4 only when status bit 2 was clear before the entry, and always jumps to the general vector. It never writes exception-status or exception-return.
- R11: Codes 11 to 31 raise the error flag with done, and raise no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Exception entry request, one cycle |
| cause_i | input | 5 | Exception cause code |
| pc_i | input | 32 | PC of the excepting instruction |
| status_i | input | 32 | Current status register |
| exccause_i | input | 32 | Current cause register |
| tlbmisc_i | input | 32 | Current TLB-misc register |
| vec_gen_i | input | 32 | General exception vector |
| vec_fast_i | input | 32 | Fast TLB-miss vector |
| done_o | output | 1 | Entry result valid, one cycle |
| err_o | output | 1 | Unhandled cause code |
| status_we_o | output | 1 | Status write strobe |
| status_o | output | 32 | New status |
| estatus_we_o | output | 1 | Exception-status write strobe |
| estatus_o | output | 32 | New exception-status |
| bstatus_we_o | output | 1 | Break-status write strobe |
| bstatus_o | output | 32 | New break-status |
| exccause_we_o | output | 1 | Cause register write strobe |
| exccause_o | output | 32 | New cause register |
| tlbmisc_we_o | output | 1 | TLB-misc write strobe |
| tlbmisc_o | output | 32 | New TLB-misc |
| ea_we_o | output | 1 | Exception-return write strobe |
| ea_o | output | 32 | New exception-return address |
| ba_we_o | output | 1 | Break-return write strobe |
| ba_o | output | 32 | New break-return address |
| pc_we_o | output | 1 | Next-PC write strobe |
| pc_o | output | 32 | Next PC |

## Verification
The assertions compare each strobed value with the inputs of the cycle before. They therefore assume that the inputs are meaningful in the cycle where the request is high, and that nothing outside the block changes the registers between the request and the commit. The stimulus enforces this. Each request drives every input and pulses the request for one cycle. The outputs are checked, and the bench then idles for one cycle before the next request. The sweep covers every 5-bit code against every combination of the four low status bits, with non-trivial upper bits in the status, cause and TLB-misc inputs, so that bits the block must preserve are exercised.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int CAUSE_W   = 5;
  localparam int CAUSE_LSB = 2;

  // status bit positions
  localparam int ST_PIE = 0;
  localparam int ST_U   = 1;
  localparam int ST_EH  = 2;
  localparam int ST_IH  = 3;

  // TLB-misc bit positions
  localparam int TM_WE  = 0;
  localparam int TM_DBL = 1;

  // cause codes
  localparam logic [CAUSE_W-1:0] C_IRQ    = 5'd0;
  localparam logic [CAUSE_W-1:0] C_MISS   = 5'd1;
  localparam logic [CAUSE_W-1:0] C_PERM_R = 5'd2;
  localparam logic [CAUSE_W-1:0] C_PERM_W = 5'd3;
  localparam logic [CAUSE_W-1:0] C_PERM_X = 5'd4;
  localparam logic [CAUSE_W-1:0] C_SUP_A  = 5'd5;
  localparam logic [CAUSE_W-1:0] C_SUP_I  = 5'd6;
  localparam logic [CAUSE_W-1:0] C_SUP_D  = 5'd7;
  localparam logic [CAUSE_W-1:0] C_TRAP   = 5'd8;
  localparam logic [CAUSE_W-1:0] C_ILL    = 5'd9;
  localparam logic [CAUSE_W-1:0] C_BRK    = 5'd10;

  typedef enum logic [2:0] {
    CL_IRQ,
    CL_MISS,
    CL_PERM,
    CL_SUPER,
    CL_TRAP,
    CL_BREAK,
    CL_BAD
  } exc_class_e;

  // write-strobe bundle, one bit per destination register
  typedef struct packed {
    logic status;
    logic estatus;
    logic bstatus;
    logic exccause;
    logic tlbmisc;
    logic ea;
    logic ba;
    logic pc;
  } exc_we_t;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause_i,
  output exc_class_e         cls_o
);

  always_comb begin
    unique case (cause_i)
      C_IRQ:                      cls_o = CL_IRQ;
      C_MISS:                     cls_o = CL_MISS;
      C_PERM_R, C_PERM_W, C_PERM_X: cls_o = CL_PERM;
      C_SUP_A, C_SUP_I, C_SUP_D:  cls_o = CL_SUPER;
      C_TRAP, C_ILL:              cls_o = CL_TRAP;
      C_BRK:                      cls_o = CL_BREAK;
      default:                    cls_o = CL_BAD;
    endcase
  end

endmodule

// File: rtl/exc_update.sv
module exc_update
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  exc_class_e         cls_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    status_i,
  input  logic [XLEN-1:0]    exccause_i,
  input  logic [XLEN-1:0]    tlbmisc_i,
  input  logic [XLEN-1:0]    vec_gen_i,
  input  logic [XLEN-1:0]    vec_fast_i,
  output exc_we_t            we_o,
  output logic               err_o,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    estatus_o,
  output logic [XLEN-1:0]    bstatus_o,
  output logic [XLEN-1:0]    exccause_o,
  output logic [XLEN-1:0]    tlbmisc_o,
  output logic [XLEN-1:0]    ea_o,
  output logic [XLEN-1:0]    ba_o,
  output logic [XLEN-1:0]    pc_o
);

  localparam logic [XLEN-1:0] PIE_M   = XLEN'(1) << ST_PIE;
  localparam logic [XLEN-1:0] U_M     = XLEN'(1) << ST_U;
  localparam logic [XLEN-1:0] EH_M    = XLEN'(1) << ST_EH;
  localparam logic [XLEN-1:0] IH_M    = XLEN'(1) << ST_IH;
  localparam logic [XLEN-1:0] WE_M    = XLEN'(1) << TM_WE;
  localparam logic [XLEN-1:0] DBL_M   = XLEN'(1) << TM_DBL;
  localparam logic [XLEN-1:0] CAUSE_M = XLEN'((1 << CAUSE_W) - 1) << CAUSE_LSB;
  localparam logic [XLEN-1:0] STEP    = XLEN'(4);

  logic            eh_before;
  logic            pie_before;
  logic [XLEN-1:0] masked;
  logic [XLEN-1:0] ret_addr;

  assign eh_before  = status_i[ST_EH];
  assign pie_before = status_i[ST_PIE];
  assign masked     = status_i & ~(PIE_M | U_M);
  assign ret_addr   = pc_i + STEP;

  always_comb begin
    we_o       = '0;
    err_o      = 1'b0;
    status_o   = masked | EH_M;
    estatus_o  = status_i;
    bstatus_o  = status_i;
    exccause_o = (exccause_i & ~CAUSE_M) | (XLEN'(cause_i) << CAUSE_LSB);
    tlbmisc_o  = tlbmisc_i;
    ea_o       = ret_addr;
    ba_o       = ret_addr;
    pc_o       = vec_gen_i;

    unique case (cls_i)
      CL_IRQ: begin
        if (pie_before) begin
          status_o    = masked | IH_M;
          we_o.status = 1'b1;
          we_o.estatus = 1'b1;
          we_o.exccause = 1'b1;
          we_o.ea     = 1'b1;
          we_o.pc     = 1'b1;
        end
      end
      CL_MISS: begin
        we_o.status   = 1'b1;
        we_o.exccause = 1'b1;
        we_o.tlbmisc  = 1'b1;
        we_o.pc       = 1'b1;
        if (!eh_before) begin
          we_o.estatus = 1'b1;
          we_o.ea      = 1'b1;
          tlbmisc_o    = (tlbmisc_i & ~DBL_M) | WE_M;
          pc_o         = vec_fast_i;
        end else begin
          tlbmisc_o    = tlbmisc_i | DBL_M;
        end
      end
      CL_PERM: begin
        we_o.status   = 1'b1;
        we_o.estatus  = 1'b1;
        we_o.exccause = 1'b1;
        we_o.ea       = 1'b1;
        we_o.pc       = 1'b1;
        if (!eh_before) begin
          we_o.tlbmisc = 1'b1;
          tlbmisc_o    = tlbmisc_i | WE_M;
        end
      end
      CL_SUPER, CL_TRAP: begin
        we_o.status   = 1'b1;
        we_o.exccause = 1'b1;
        we_o.pc       = 1'b1;
        if (!eh_before) begin
          we_o.estatus = 1'b1;
          we_o.ea      = 1'b1;
        end
      end
      CL_BREAK: begin
        we_o.status   = 1'b1;
        we_o.exccause = 1'b1;
        we_o.pc       = 1'b1;
        if (!eh_before) begin
          we_o.bstatus = 1'b1;
          we_o.ba      = 1'b1;
        end
      end
      default: err_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    status_i,
  input  logic [XLEN-1:0]    exccause_i,
  input  logic [XLEN-1:0]    tlbmisc_i,
  input  logic [XLEN-1:0]    vec_gen_i,
  input  logic [XLEN-1:0]    vec_fast_i,
  output logic               done_o,
  output logic               err_o,
  output logic               status_we_o,
  output logic [XLEN-1:0]    status_o,
  output logic               estatus_we_o,
  output logic [XLEN-1:0]    estatus_o,
  output logic               bstatus_we_o,
  output logic [XLEN-1:0]    bstatus_o,
  output logic               exccause_we_o,
  output logic [XLEN-1:0]    exccause_o,
  output logic               tlbmisc_we_o,
  output logic [XLEN-1:0]    tlbmisc_o,
  output logic               ea_we_o,
  output logic [XLEN-1:0]    ea_o,
  output logic               ba_we_o,
  output logic [XLEN-1:0]    ba_o,
  output logic               pc_we_o,
  output logic [XLEN-1:0]    pc_o
);

  localparam int NREG = 8;

  exc_class_e      cls;
  exc_we_t         we_n, we_q;
  logic            err_n, err_q, done_q;
  logic [XLEN-1:0] val_n [NREG];
  logic [XLEN-1:0] val_q [NREG];

  exc_classify u_cls (
    .cause_i (cause_i),
    .cls_o   (cls)
  );

  exc_update #(.XLEN(XLEN)) u_upd (
    .cls_i      (cls),
    .cause_i    (cause_i),
    .pc_i       (pc_i),
    .status_i   (status_i),
    .exccause_i (exccause_i),
    .tlbmisc_i  (tlbmisc_i),
    .vec_gen_i  (vec_gen_i),
    .vec_fast_i (vec_fast_i),
    .we_o       (we_n),
    .err_o      (err_n),
    .status_o   (val_n[0]),
    .estatus_o  (val_n[1]),
    .bstatus_o  (val_n[2]),
    .exccause_o (val_n[3]),
    .tlbmisc_o  (val_n[4]),
    .ea_o       (val_n[5]),
    .ba_o       (val_n[6]),
    .pc_o       (val_n[7])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      we_q   <= '0;
    end else begin
      done_q <= req_i;
      err_q  <= req_i & err_n;
      we_q   <= req_i ? we_n : '0;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_val
    always_ff @(posedge clk) begin
      if (!rst_n)     val_q[g] <= '0;
      else if (req_i) val_q[g] <= val_n[g];
    end
  end

  assign done_o        = done_q;
  assign err_o         = err_q;
  assign status_we_o   = we_q.status;
  assign estatus_we_o  = we_q.estatus;
  assign bstatus_we_o  = we_q.bstatus;
  assign exccause_we_o = we_q.exccause;
  assign tlbmisc_we_o  = we_q.tlbmisc;
  assign ea_we_o       = we_q.ea;
  assign ba_we_o       = we_q.ba;
  assign pc_we_o       = we_q.pc;
  assign status_o      = val_q[0];
  assign estatus_o     = val_q[1];
  assign bstatus_o     = val_q[2];
  assign exccause_o    = val_q[3];
  assign tlbmisc_o     = val_q[4];
  assign ea_o          = val_q[5];
  assign ba_o          = val_q[6];
  assign pc_o          = val_q[7];

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_i,
  input logic [CAUSE_W-1:0] cause_i,
  input logic [XLEN-1:0]    pc_i,
  input logic [XLEN-1:0]    status_i,
  input logic [XLEN-1:0]    vec_gen_i,
  input logic [XLEN-1:0]    vec_fast_i,
  input logic               done_o,
  input logic               err_o,
  input logic               status_we_o,
  input logic [XLEN-1:0]    status_o,
  input logic               estatus_we_o,
  input logic [XLEN-1:0]    estatus_o,
  input logic               bstatus_we_o,
  input logic [XLEN-1:0]    bstatus_o,
  input logic               exccause_we_o,
  input logic [XLEN-1:0]    exccause_o,
  input logic               tlbmisc_we_o,
  input logic               ea_we_o,
  input logic [XLEN-1:0]    ea_o,
  input logic               ba_we_o,
  input logic [XLEN-1:0]    ba_o,
  input logic               pc_we_o,
  input logic [XLEN-1:0]    pc_o
);

  logic any_we;
  assign any_we = status_we_o | estatus_we_o | bstatus_we_o | exccause_we_o |
                  tlbmisc_we_o | ea_we_o | ba_we_o | pc_we_o;

  // R2
  req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> done_o);

  // R2
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(req_i));

  // R2
  we_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_we || err_o) |-> done_o);

  // R11
  err_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !any_we);

  // R3
  status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_we_o |-> (!status_o[ST_PIE] && !status_o[ST_U] &&
                     (status_o[ST_EH] || status_o[ST_IH])));

  // R4
  cause_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exccause_we_o |-> exccause_o[CAUSE_LSB +: CAUSE_W] == $past(cause_i));

  // R5
  estatus_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    estatus_we_o |-> (estatus_o == $past(status_i) &&
                      ea_o == $past(pc_i) + XLEN'(4)));

  // R6
  vector_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_o |-> (pc_o == $past(vec_gen_i) || pc_o == $past(vec_fast_i)));

  // R7
  nested_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(cause_i) == C_MISS && $past(status_i[ST_EH]))
      |-> (!estatus_we_o && !ea_we_o && pc_o == $past(vec_gen_i)));

  // R10
  break_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_we_o |-> (ba_o == $past(pc_i) + XLEN'(4) &&
                 bstatus_o == $past(status_i) && !estatus_we_o && !ea_we_o));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_i         (req_i),
  .cause_i       (cause_i),
  .pc_i          (pc_i),
  .status_i      (status_i),
  .vec_gen_i     (vec_gen_i),
  .vec_fast_i    (vec_fast_i),
  .done_o        (done_o),
  .err_o         (err_o),
  .status_we_o   (status_we_o),
  .status_o      (status_o),
  .estatus_we_o  (estatus_we_o),
  .estatus_o     (estatus_o),
  .bstatus_we_o  (bstatus_we_o),
  .bstatus_o     (bstatus_o),
  .exccause_we_o (exccause_we_o),
  .exccause_o    (exccause_o),
  .tlbmisc_we_o  (tlbmisc_we_o),
  .ea_we_o       (ea_we_o),
  .ea_o          (ea_o),
  .ba_we_o       (ba_we_o),
  .ba_o          (ba_o),
  .pc_we_o       (pc_we_o),
  .pc_o          (pc_o)
);

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [4:0]  cause = '0;
  logic [31:0] pc = '0, st = '0, ecin = '0, tmin = '0, vg = '0, vf = '0;
  logic        done, err;
  logic        st_we, est_we, bst_we, ec_we, tm_we, ea_we, ba_we, pc_we;
  logic [31:0] st_o, est_o, bst_o, ec_o, tm_o, ea_o, ba_o, pc_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cause_i(cause), .pc_i(pc),
    .status_i(st), .exccause_i(ecin), .tlbmisc_i(tmin),
    .vec_gen_i(vg), .vec_fast_i(vf),
    .done_o(done), .err_o(err),
    .status_we_o(st_we), .status_o(st_o),
    .estatus_we_o(est_we), .estatus_o(est_o),
    .bstatus_we_o(bst_we), .bstatus_o(bst_o),
    .exccause_we_o(ec_we), .exccause_o(ec_o),
    .tlbmisc_we_o(tm_we), .tlbmisc_o(tm_o),
    .ea_we_o(ea_we), .ea_o(ea_o),
    .ba_we_o(ba_we), .ba_o(ba_o),
    .pc_we_o(pc_we), .pc_o(pc_o)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "WATCHDOG", "timeout", 32'(cycles), 32'd150000);
      finish_run();
    end
  end

  // expected values
  logic [7:0]  e_we;   // st,est,bst,ec,tm,ea,ba,pc
  logic        e_err;
  logic [31:0] e_st, e_ec, e_tm, e_pc;
  string       rq;

  task automatic expect_calc();
    bit eh, pie;
    eh  = st[2];
    pie = st[0];
    e_we  = 8'h00;
    e_err = 1'b0;
    e_st  = (st & 32'hFFFF_FFFC) | 32'h4;
    e_ec  = (ecin & 32'hFFFF_FF83) | ({27'd0, cause} * 32'd4);
    e_tm  = tmin;
    e_pc  = vg;
    if (cause == 0) begin
      rq = "R5";
      if (pie) begin
        e_st = (st & 32'hFFFF_FFFC) | 32'h8;
        e_we = 8'b1101_0101;
      end
    end else if (cause == 1) begin
      if (!eh) begin
        rq = "R6";
        e_we = 8'b1101_1101;
        e_tm = (tmin & 32'hFFFF_FFFD) | 32'h1;
        e_pc = vf;
      end else begin
        rq = "R7";
        e_we = 8'b1001_1001;
        e_tm = tmin | 32'h2;
      end
    end else if (cause >= 2 && cause <= 4) begin
      rq = "R8";
      e_we = eh ? 8'b1101_0101 : 8'b1101_1101;
      if (!eh) e_tm = tmin | 32'h1;
    end else if (cause >= 5 && cause <= 9) begin
      rq = "R9";
      e_we = eh ? 8'b1001_0001 : 8'b1101_0101;
    end else if (cause == 10) begin
      rq = "R10";
      e_we = eh ? 8'b1001_0001 : 8'b1011_0011;
    end else begin
      rq = "R11";
      e_err = 1'b1;
    end
  endtask

  initial begin
    logic [7:0] a_we;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(!done && !err && {st_we,est_we,bst_we,ec_we,tm_we,ea_we,ba_we,pc_we} == 0,
          "R1", "reset strobes", {30'd0, done, err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !err, "R1", "post-reset done", {31'd0, done}, 32'd0);

    for (int c = 0; c < 32; c++) begin
      for (int s = 0; s < 16; s++) begin
        cause = 5'(c);
        st    = 32'hA5A5_0000 | 32'(s) | (32'(c) << 8);
        ecin  = 32'hDEAD_BE00 | 32'(s * 9) | 32'h7C;
        tmin  = 32'h0F0F_0000 | 32'((s * 5) & 3) | (32'(c) << 4);
        pc    = 32'h0000_1000 + 32'(c * 256) + 32'(s * 4);
        vg    = 32'h0000_0120;
        vf    = 32'hC000_0100;
        expect_calc();
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        a_we = {st_we, est_we, bst_we, ec_we, tm_we, ea_we, ba_we, pc_we};
        // R2
        check(done, "R2", "done pulse", {31'd0, done}, 32'd1);
        // R11
        check(err == e_err, rq, "err", {31'd0, err}, {31'd0, e_err});
        check(a_we == e_we, rq, "strobes", {24'd0, a_we}, {24'd0, e_we});
        if (st_we && e_we[7]) check(st_o == e_st, "R3", "status", st_o, e_st);
        if (ec_we && e_we[4]) check(ec_o == e_ec, "R4", "cause reg", ec_o, e_ec);
        if (est_we && e_we[6]) check(est_o == st, rq, "estatus", est_o, st);
        if (bst_we && e_we[5]) check(bst_o == st, rq, "bstatus", bst_o, st);
        if (tm_we && e_we[3]) check(tm_o == e_tm, rq, "tlbmisc", tm_o, e_tm);
        if (ea_we && e_we[2]) check(ea_o == pc + 4, rq, "ea", ea_o, pc + 4);
        if (ba_we && e_we[1]) check(ba_o == pc + 4, rq, "ba", ba_o, pc + 4);
        if (pc_we && e_we[0]) check(pc_o == e_pc, rq, "next pc", pc_o, e_pc);
        @(negedge clk);
        a_we = {st_we, est_we, bst_we, ec_we, tm_we, ea_we, ba_we, pc_we};
        // R2: single-cycle pulse, strobes drop with it
        check(!done && !err && a_we == 0, "R2", "idle after done",
              {23'd0, done, a_we}, 32'd0);
      end
    end
    finish_run();
  end

endmodule